// File: doc/BRIEF.md
# Banked Three-Wire Register Bus Master

This block drives a slave chip's half-duplex three-wire register bus: a clock line, a data line that the master either drives or releases, and a direction line that is high while the master writes. A host asks for single-byte register accesses through a request/acknowledge handshake and gives a 5-bit logical address. Four operations are supported: a plain write, a read, a set-bits operation and a clear-bits operation.

The slave splits its registers into two banks and keeps one bank selected at a time. The master remembers which bank it last selected. It sends a bank-select transaction only when the target bank differs from that bank, or when no bank is known yet. It also keeps a shadow copy of every register value the host has written, so set-bits and clear-bits need no bus read. Two registers have values that are rewritten on their way to the bus: a capacitor setting whose encoding is folded, and a register in which some bits must always be sent as ones.

The host holds `req_i` and the request fields steady until `ack_o` pulses. It then drops `req_i`.

Top module: `tw_bank_master`

## Requirements
- R1: Logical addresses with bit 4 set select bank B and go out with physical address `addr[3:0]` (the logical address minus 0x10). Logical addresses with bit 4 clear select bank A with the same physical address. The two banks are separate register spaces.
- R2: A bank-select transaction is a write transaction of two bytes. It sends the bank code (0x01 for bank A, 0x02 for bank B) and then the bank-select register address 0x0F. It comes before an access only when the remembered bank is unknown or differs from the target. The remembered bank is unknown after reset and after any cycle in which `powered_i` is low.
- R3: A register write is one transaction: `bus_dir_o` and `bus_oe_o` go high, the value byte is sent, then the physical address byte, and then both lines go low.
- R4: Each bit holds `bus_clk_o` low for DELAY_UNIT clocks with the data bit on `bus_dout_o`, then high for DELAY_UNIT clocks. The data bit does not change while the clock is high. The clock idles high. Bits go out least significant first.
- R5: A read sends a transaction that carries only the physical address. It then clocks eight bits in with the data line released, sampling `bus_din_i` at the end of each low phase, least significant bit first. The byte is returned on `rdata_o` with `ack_o`.
- R6: The op code `op_i` is 0 for write, 1 for read, 2 for set-bits and 3 for clear-bits. Set-bits writes shadow OR `wdata_i`. Clear-bits writes shadow AND NOT `wdata_i`. The shadow keeps the logical (not remapped) value and resets to zero.
- R7: Logical capacitor register 0x04 takes a value L from 0 to 191. It is sent as 255−L when L is below 64 and as 191−L otherwise.
- R8: Logical register 0x16 is always sent with bits 4, 1 and 0 set.
- R9: While `powered_i` is low, a request causes no bus activity and is acknowledged. A read returns 0. A write, set-bits or clear-bits still updates the shadow.
- R10: `ack_o` is a single-cycle pulse. When it is high, the bus is idle: clock high, direction low, data released.
- R11: `bus_oe_o` is high only while `bus_dir_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| powered_i | input | 1 | Bus interface powered; low drops bus traffic |
| req_i | input | 1 | Request, held until ack |
| op_i | input | 2 | Operation code (R6) |
| addr_i | input | 5 | Logical register address |
| wdata_i | input | 8 | Write value or bit mask |
| ack_o | output | 1 | Single-cycle completion pulse |
| rdata_o | output | 8 | Read result, valid with ack |
| bus_clk_o | output | 1 | Bus clock line |
| bus_dir_o | output | 1 | Direction line, high while the master writes |
| bus_oe_o | output | 1 | Output enable for the data line |
| bus_dout_o | output | 1 | Data line value when driven |
| bus_din_i | input | 1 | Data line value seen from the slave |

## Verification
The bound checker watches the line discipline on every cycle. It checks that the data line is enabled only while the direction line is high, that the data bit holds steady through each high clock phase, that a transaction opens with the clock high, and that the acknowledge is a lone pulse that comes with an idle bus. A bus slave model in the bench decodes each transaction and answers reads. Only that model's scenarios show whether the right bytes went out in the right order: bank switches skipped or sent, remapped capacitor and forced-bit values, shadow-based set and clear results, and unpowered requests leaving the bus silent while still updating the shadow.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } tw_op_e;

    typedef enum logic [2:0] {
        T_IDLE,
        T_OPEN,
        T_SEND,
        T_CLOSE,
        T_RECV,
        T_ACK
    } tw_state_e;

    typedef enum logic [1:0] {
        P_IDLE,
        P_LOW,
        P_HIGH
    } tw_phase_e;

endpackage

// File: rtl/tw_value_remap.sv
module tw_value_remap
    import tw_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int CAP_REG    = 'h04,
    parameter int FORCE_REG  = 'h16,
    parameter int FORCE_BITS = 'h13
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] val_i,
    output logic [BYTE_W-1:0] val_o
);

    localparam logic [BYTE_W-1:0] FOLD_LOW  = BYTE_W'(255);
    localparam logic [BYTE_W-1:0] FOLD_HIGH = BYTE_W'(191);
    localparam logic [BYTE_W-1:0] SPLIT     = BYTE_W'(64);

    always_comb begin
        val_o = val_i;
        if (addr_i == ADDR_W'(CAP_REG)) begin
            val_o = (val_i < SPLIT) ? (FOLD_LOW - val_i) : (FOLD_HIGH - val_i);
        end else if (addr_i == ADDR_W'(FORCE_REG)) begin
            val_o = val_i | BYTE_W'(FORCE_BITS);
        end
    end

endmodule

// File: rtl/tw_shadow_ram.sv
module tw_shadow_ram
    import tw_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem_q [DEPTH];

    assign rdata_o = mem_q[addr_i];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (we_i && (addr_i == ADDR_W'(g))) begin
                mem_q[g] <= wdata_i;
            end
        end
    end

endmodule

// File: rtl/tw_bit_serdes.sv
module tw_bit_serdes
    import tw_pkg::*;
#(
    parameter int DELAY_UNIT = 4,
    parameter bit LSB_FIRST  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              recv_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              din_i,
    output logic              done_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              sclk_o,
    output logic              sdo_o
);

    localparam int CW = (DELAY_UNIT > 1) ? $clog2(DELAY_UNIT) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(DELAY_UNIT - 1);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    typedef struct packed {
        tw_phase_e         ph;
        logic [CW-1:0]     cnt;
        logic [BIT_W-1:0]  bitn;
        logic [BYTE_W-1:0] sh;
        logic              recv;
        logic              done;
        logic              sclk;
        logic              sdo;
    } ser_t;

    ser_t ser_d, ser_q;

    function automatic logic head_bit(input logic [BYTE_W-1:0] b);
        return LSB_FIRST ? b[0] : b[BYTE_W-1];
    endfunction

    function automatic logic [BYTE_W-1:0] drop_bit(input logic [BYTE_W-1:0] b);
        return LSB_FIRST ? (b >> 1) : (b << 1);
    endfunction

    function automatic logic [BYTE_W-1:0] take_bit(input logic [BYTE_W-1:0] b, input logic d);
        return LSB_FIRST ? {d, b[BYTE_W-1:1]} : {b[BYTE_W-2:0], d};
    endfunction

    always_comb begin
        ser_d      = ser_q;
        ser_d.done = 1'b0;
        unique case (ser_q.ph)
            P_IDLE: begin
                ser_d.sclk = 1'b1;
                if (start_i) begin
                    ser_d.ph   = P_LOW;
                    ser_d.cnt  = CNT_TOP;
                    ser_d.bitn = '0;
                    ser_d.sh   = byte_i;
                    ser_d.recv = recv_i;
                    ser_d.sclk = 1'b0;
                    ser_d.sdo  = recv_i ? 1'b0 : head_bit(byte_i);
                end
            end
            P_LOW: begin
                if (ser_q.cnt == '0) begin
                    ser_d.ph   = P_HIGH;
                    ser_d.cnt  = CNT_TOP;
                    ser_d.sclk = 1'b1;
                    if (ser_q.recv) begin
                        ser_d.sh = take_bit(ser_q.sh, din_i);
                    end
                end else begin
                    ser_d.cnt = ser_q.cnt - 1'b1;
                end
            end
            P_HIGH: begin
                if (ser_q.cnt == '0) begin
                    if (ser_q.bitn == LAST_BIT) begin
                        ser_d.ph   = P_IDLE;
                        ser_d.done = 1'b1;
                    end else begin
                        ser_d.ph   = P_LOW;
                        ser_d.cnt  = CNT_TOP;
                        ser_d.bitn = ser_q.bitn + 1'b1;
                        ser_d.sclk = 1'b0;
                        if (!ser_q.recv) begin
                            ser_d.sh  = drop_bit(ser_q.sh);
                            ser_d.sdo = head_bit(drop_bit(ser_q.sh));
                        end
                    end
                end else begin
                    ser_d.cnt = ser_q.cnt - 1'b1;
                end
            end
            default: ser_d.ph = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q      <= '0;
            ser_q.ph   <= P_IDLE;
            ser_q.sclk <= 1'b1;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign done_o = ser_q.done;
    assign byte_o = ser_q.sh;
    assign sclk_o = ser_q.sclk;
    assign sdo_o  = ser_q.sdo;

endmodule

// File: rtl/tw_bank_master.sv
module tw_bank_master
    import tw_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DELAY_UNIT  = 4,
    parameter bit LSB_FIRST   = 1'b1,
    parameter int BANK_A_CODE = 'h01,
    parameter int BANK_B_CODE = 'h02,
    parameter int BANK_SEL_REG = 'h0F,
    parameter int CAP_REG     = 'h04,
    parameter int FORCE_REG   = 'h16,
    parameter int FORCE_BITS  = 'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              powered_i,
    input  logic              req_i,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic              ack_o,
    output logic [7:0]        rdata_o,
    output logic              bus_clk_o,
    output logic              bus_dir_o,
    output logic              bus_oe_o,
    output logic              bus_dout_o,
    input  logic              bus_din_i
);

    localparam int BANK_BIT = ADDR_W - 1;
    localparam int CW = (DELAY_UNIT > 1) ? $clog2(DELAY_UNIT) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(DELAY_UNIT - 1);

    typedef struct packed {
        tw_state_e         st;
        logic [CW-1:0]     cnt;
        logic              idx;
        logic              two;
        logic              sw_pend;
        logic              is_read;
        logic [BYTE_W-1:0] b0;
        logic [BYTE_W-1:0] b1;
        logic [BYTE_W-1:0] m0;
        logic [BYTE_W-1:0] m1;
        logic              mtwo;
        logic              bank_vld;
        logic              bank_hi;
        logic [BYTE_W-1:0] rdata;
        logic              ack;
        logic              dir;
        logic              oe;
        logic              start;
        logic              recv;
        logic [BYTE_W-1:0] tx;
    } mst_t;

    mst_t mst_d, mst_q;

    tw_op_e            op;
    logic              tgt_hi;
    logic [BYTE_W-1:0] phys;
    logic [BYTE_W-1:0] shadow_val;
    logic [BYTE_W-1:0] new_val;
    logic [BYTE_W-1:0] wire_val;
    logic              shadow_we;
    logic              eng_done;
    logic [BYTE_W-1:0] eng_byte;

    assign op     = tw_op_e'(op_i);
    assign tgt_hi = addr_i[BANK_BIT];
    assign phys   = BYTE_W'(addr_i[BANK_BIT-1:0]);

    always_comb begin
        unique case (op)
            OP_SET:   new_val = shadow_val | wdata_i;
            OP_CLEAR: new_val = shadow_val & ~wdata_i;
            default:  new_val = wdata_i;
        endcase
    end

    assign shadow_we = (mst_q.st == T_IDLE) && req_i && (op != OP_READ);

    tw_shadow_ram #(
        .ADDR_W (ADDR_W)
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (shadow_we),
        .addr_i  (addr_i),
        .wdata_i (new_val),
        .rdata_o (shadow_val)
    );

    tw_value_remap #(
        .ADDR_W     (ADDR_W),
        .CAP_REG    (CAP_REG),
        .FORCE_REG  (FORCE_REG),
        .FORCE_BITS (FORCE_BITS)
    ) u_remap (
        .addr_i (addr_i),
        .val_i  (new_val),
        .val_o  (wire_val)
    );

    tw_bit_serdes #(
        .DELAY_UNIT (DELAY_UNIT),
        .LSB_FIRST  (LSB_FIRST)
    ) u_serdes (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (mst_q.start),
        .recv_i  (mst_q.recv),
        .byte_i  (mst_q.tx),
        .din_i   (bus_din_i),
        .done_o  (eng_done),
        .byte_o  (eng_byte),
        .sclk_o  (bus_clk_o),
        .sdo_o   (bus_dout_o)
    );

    always_comb begin
        mst_d       = mst_q;
        mst_d.start = 1'b0;
        mst_d.ack   = 1'b0;
        unique case (mst_q.st)
            T_IDLE: begin
                if (req_i) begin
                    if (!powered_i) begin
                        mst_d.rdata = '0;
                        mst_d.ack   = 1'b1;
                        mst_d.st    = T_ACK;
                    end else begin
                        mst_d.is_read  = (op == OP_READ);
                        mst_d.m0       = (op == OP_READ) ? phys : wire_val;
                        mst_d.m1       = phys;
                        mst_d.mtwo     = (op != OP_READ);
                        mst_d.bank_vld = 1'b1;
                        mst_d.bank_hi  = tgt_hi;
                        if (!mst_q.bank_vld || (mst_q.bank_hi != tgt_hi)) begin
                            mst_d.sw_pend = 1'b1;
                            mst_d.b0      = tgt_hi ? BYTE_W'(BANK_B_CODE) : BYTE_W'(BANK_A_CODE);
                            mst_d.b1      = BYTE_W'(BANK_SEL_REG);
                            mst_d.two     = 1'b1;
                        end else begin
                            mst_d.sw_pend = 1'b0;
                            mst_d.b0      = (op == OP_READ) ? phys : wire_val;
                            mst_d.b1      = phys;
                            mst_d.two     = (op != OP_READ);
                        end
                        mst_d.st  = T_OPEN;
                        mst_d.cnt = CNT_TOP;
                        mst_d.dir = 1'b1;
                        mst_d.oe  = 1'b1;
                    end
                end
            end
            T_OPEN: begin
                if (mst_q.cnt == '0) begin
                    mst_d.st    = T_SEND;
                    mst_d.idx   = 1'b0;
                    mst_d.start = 1'b1;
                    mst_d.recv  = 1'b0;
                    mst_d.tx    = mst_q.b0;
                end else begin
                    mst_d.cnt = mst_q.cnt - 1'b1;
                end
            end
            T_SEND: begin
                if (eng_done) begin
                    if (!mst_q.idx && mst_q.two) begin
                        mst_d.idx   = 1'b1;
                        mst_d.start = 1'b1;
                        mst_d.tx    = mst_q.b1;
                    end else begin
                        mst_d.st  = T_CLOSE;
                        mst_d.cnt = CNT_TOP;
                        mst_d.oe  = 1'b0;
                        mst_d.dir = 1'b0;
                    end
                end
            end
            T_CLOSE: begin
                if (mst_q.cnt != '0) begin
                    mst_d.cnt = mst_q.cnt - 1'b1;
                end else if (mst_q.sw_pend) begin
                    mst_d.sw_pend = 1'b0;
                    mst_d.b0      = mst_q.m0;
                    mst_d.b1      = mst_q.m1;
                    mst_d.two     = mst_q.mtwo;
                    mst_d.st      = T_OPEN;
                    mst_d.cnt     = CNT_TOP;
                    mst_d.dir     = 1'b1;
                    mst_d.oe      = 1'b1;
                end else if (mst_q.is_read) begin
                    mst_d.st    = T_RECV;
                    mst_d.start = 1'b1;
                    mst_d.recv  = 1'b1;
                    mst_d.tx    = '0;
                end else begin
                    mst_d.st  = T_ACK;
                    mst_d.ack = 1'b1;
                end
            end
            T_RECV: begin
                if (eng_done) begin
                    mst_d.rdata = eng_byte;
                    mst_d.st    = T_ACK;
                    mst_d.ack   = 1'b1;
                end
            end
            T_ACK: begin
                mst_d.st = T_IDLE;
            end
            default: mst_d.st = T_IDLE;
        endcase
        if (!powered_i) begin
            mst_d.bank_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst_q    <= '0;
            mst_q.st <= T_IDLE;
        end else begin
            mst_q <= mst_d;
        end
    end

    assign ack_o     = mst_q.ack;
    assign rdata_o   = mst_q.rdata;
    assign bus_dir_o = mst_q.dir;
    assign bus_oe_o  = mst_q.oe;

endmodule

// File: rtl/tw_bank_master_chk.sv
module tw_bank_master_chk (
    input logic clk,
    input logic rst_n,
    input logic ack_o,
    input logic bus_clk_o,
    input logic bus_dir_o,
    input logic bus_oe_o,
    input logic bus_dout_o
);

    p_oe_needs_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> bus_dir_o);

    p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    p_ack_bus_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (bus_clk_o && !bus_dir_o && !bus_oe_o));

    p_open_clk_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_dir_o) |-> bus_clk_o);

    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && bus_clk_o && $past(bus_clk_o) && $past(bus_oe_o)) |-> $stable(bus_dout_o));

endmodule

bind tw_bank_master tw_bank_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_o      (ack_o),
    .bus_clk_o  (bus_clk_o),
    .bus_dir_o  (bus_dir_o),
    .bus_oe_o   (bus_oe_o),
    .bus_dout_o (bus_dout_o)
);

// File: tb/tw_bank_master_bench.sv
module tw_bank_master_bench;

    localparam int UNIT   = 4;
    localparam logic [7:0] CODE_B = 8'h02;
    localparam logic [7:0] BSEL   = 8'h0F;
    localparam logic [4:0] CAP    = 5'h04;
    localparam logic [4:0] FORCE  = 5'h16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       powered = 1'b1;
    logic       req = 1'b0;
    logic [1:0] op = 2'd0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       ack;
    logic [7:0] rdata;
    logic       bus_clk, bus_dir, bus_oe, bus_dout;
    logic       bus_din = 1'b0;

    always #2 clk = ~clk;

    tw_bank_master u_tw_bank_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .powered_i  (powered),
        .req_i      (req),
        .op_i       (op),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .ack_o      (ack),
        .rdata_o    (rdata),
        .bus_clk_o  (bus_clk),
        .bus_dir_o  (bus_dir),
        .bus_oe_o   (bus_oe),
        .bus_dout_o (bus_dout),
        .bus_din_i  (bus_din)
    );

    int nvec = 0;
    int nbad = 0;
    bit finished = 0;

    // slave model
    logic [7:0] smem [2][16];
    logic [7:0] txb [4];
    int  nb = 0, bitn = 0, ntx = 0, nsw = 0, rbit = 0;
    bit  sbank = 0;
    logic [3:0] ptr = '0;
    logic [7:0] cur = '0;

    always @(posedge bus_clk) begin
        if (bus_dir === 1'b1 && bus_oe === 1'b1) begin
            cur[bitn] = bus_dout;
            bitn++;
            if (bitn == 8) begin
                if (nb < 4) txb[nb] = cur;
                nb++;
                bitn = 0;
            end
        end
    end

    always @(negedge bus_dir) begin
        if (nb == 2 && txb[1] == BSEL) begin
            sbank = (txb[0] == CODE_B);
            nsw++;
        end else if (nb == 2) begin
            smem[sbank][txb[1][3:0]] = txb[0];
        end else if (nb == 1) begin
            ptr  = txb[0][3:0];
            rbit = 0;
        end
        ntx++;
        nb   = 0;
        bitn = 0;
    end

    always @(negedge bus_clk) begin
        if (bus_dir === 1'b0 && rbit < 8) begin
            bus_din = smem[sbank][ptr][rbit];
            rbit++;
        end
    end

    // bit timing monitor (R4)
    int lowrun = 0, pulses = 0, terr = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_clk === 1'b0) lowrun++;
            else begin
                if (lowrun != 0) begin
                    pulses++;
                    if (lowrun != UNIT) terr++;
                end
                lowrun = 0;
            end
        end
    end

    // expected-value model
    logic [7:0] esh [32];
    bit ev = 0, eh = 0;

    function automatic logic [7:0] remap(input logic [4:0] a, input logic [7:0] v);
        if (a == CAP) return (v < 8'd64) ? 8'(8'd255 - v) : 8'(8'd191 - v);
        if (a == FORCE) return v | 8'h13;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [4:0] a, input logic [7:0] d,
                          input bit pw, input string tag);
        int tx0 = ntx;
        int sw0 = nsw;
        logic [7:0] nv, got;
        bit hi = a[4];
        bit expsw;
        @(negedge clk);
        powered = pw; req = 1'b1; op = o; addr = a; wdata = d;
        @(negedge clk);
        while (ack !== 1'b1) @(negedge clk);
        got = rdata;
        chk(bus_clk === 1'b1 && bus_dir === 1'b0 && bus_oe === 1'b0, "R10 idle bus at ack",
            {bus_clk, bus_dir, bus_oe}, 3'b100);
        req = 1'b0;
        @(negedge clk);
        chk(ack === 1'b0, "R10 ack pulse", ack, 0);
        case (o)
            2'd2: nv = esh[a] | d;
            2'd3: nv = esh[a] & ~d;
            default: nv = d;
        endcase
        if (o != 2'd1) esh[a] = nv;
        if (!pw) begin
            ev = 0;
            chk(ntx == tx0, {"R9 no bus traffic ", tag}, ntx - tx0, 0);
            if (o == 2'd1) chk(got == 8'h00, {"R9 read zero ", tag}, got, 0);
        end else begin
            expsw = !ev || (eh != hi);
            ev = 1; eh = hi;
            chk((nsw - sw0) == int'(expsw), {"R2 bank switch ", tag}, nsw - sw0, int'(expsw));
            chk((ntx - tx0) == int'(expsw) + 1, {"R3 txn count ", tag}, ntx - tx0, int'(expsw) + 1);
            if (o == 2'd1)
                chk(got == smem[hi][a[3:0]], {"R5 read ", tag}, got, smem[hi][a[3:0]]);
            else
                chk(smem[hi][a[3:0]] == remap(a, nv), {"R3 R6 value ", tag},
                    smem[hi][a[3:0]], remap(a, nv));
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 16; i++) smem[b][i] = 8'($urandom);
        for (int i = 0; i < 32; i++) esh[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(bus_clk === 1'b1 && bus_dir === 1'b0 && bus_oe === 1'b0 && ack === 1'b0,
            "R10 reset state", {bus_clk, bus_dir, bus_oe, ack}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_op(2'd0, 5'h02, 8'h80, 1, "R2 first access R4 lsb order");
        run_op(2'd0, 5'h03, 8'h5A, 1, "R2 same bank");
        run_op(2'd0, 5'h13, 8'hA5, 1, "R1 bank B");
        chk(smem[0][3] == 8'h5A, "R1 banks separate", smem[0][3], 8'h5A);
        run_op(2'd1, 5'h13, 8'h00, 1, "R5 read bank B");
        run_op(2'd1, 5'h08, 8'h00, 1, "R5 read bank A");
        run_op(2'd0, CAP, 8'd0,   1, "R7 cap 0");
        run_op(2'd0, CAP, 8'd63,  1, "R7 cap 63");
        run_op(2'd0, CAP, 8'd64,  1, "R7 cap 64");
        run_op(2'd0, CAP, 8'd191, 1, "R7 cap 191");
        run_op(2'd0, FORCE, 8'h00, 1, "R8 forced");
        run_op(2'd2, FORCE, 8'h04, 1, "R6 R8 set keeps logical");
        run_op(2'd3, FORCE, 8'h10, 1, "R6 clear");
        run_op(2'd2, 5'h05, 8'h0C, 1, "R6 set from zero");
        run_op(2'd0, 5'h07, 8'h3C, 0, "R9 unpowered write");
        run_op(2'd1, 5'h07, 8'h00, 0, "R9 unpowered read");
        run_op(2'd2, 5'h07, 8'h01, 1, "R9 R2 shadow kept, cache reset");

        for (int n = 0; n < 200; n++) begin
            logic [4:0] a;
            logic [7:0] d;
            logic [1:0] o;
            bit pw;
            do a = 5'($urandom); while (a[3:0] == 4'hF);
            o  = 2'($urandom);
            d  = 8'($urandom);
            pw = ($urandom % 10) != 0;
            if (a == CAP) begin
                if (o == 2'd0) d = 8'($urandom % 192);
                else o = 2'd1;
            end
            run_op(o, a, d, pw, "random");
        end

        chk(terr == 0 && pulses > 0, "R4 clock low width", terr, 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule